// File: doc/BRIEF.md
# Receive Packet Copy Engine

This block drains received packets from a packet FIFO into host memory, one software-issued descriptor at a time. Software posts a 64-bit descriptor that carries a destination buffer address and a requested byte count. Once receive is enabled and a packet is waiting, the engine issues one memory write request for the bytes it is about to copy. It then records the result in a 64-bit done word that software reads back.

A packet larger than one descriptor, or larger than the per-copy ceiling, is delivered over several descriptors. Each later copy resumes at the byte offset where the previous one stopped. The head packet leaves the FIFO only when its last byte has gone out. Every completed copy raises a one-cycle data-moved pulse. The copy that finishes a packet also raises a packet-received pulse and pops the FIFO.

Top module: `rx_copy_engine`

## Requirements
- R1: After reset the done word reads zero, and `mem_req`, `fifo_pop`, `irq_rx_data` and `irq_rx_done` are low.
- R2: A descriptor places the buffer address in bits 39:0 and the requested length in bits 59:40. A descriptor write that arrives while an earlier descriptor is still pending, including its completion cycle, is ignored.
- R3: No copy starts while `cfg_rx_en` is low. A pending descriptor is kept and is served once `cfg_rx_en` rises.
- R4: A pending descriptor with an empty FIFO waits without issuing any request. It proceeds once `fifo_pkt_cnt` becomes nonzero.
- R5: The copy length is the smallest of three values: the descriptor length, `max_copy` and the bytes still undelivered in the head packet. `mem_req` stays high until `mem_ack`, with `mem_addr`, `mem_len` and `mem_off` unchanged.
- R6: A partly delivered packet continues on the next descriptor, and `mem_off` equals the number of bytes already delivered. The FIFO is popped only when the undelivered count reaches zero.
- R7: A copy of length zero issues no memory request. It still completes and returns a done word with length 0, with the more-data bit set if packet bytes remain.
- R8: The done word is packed as follows. Bit 63 is complete. Bit 32 is set when bytes of the packet remain. Bits 27:20 hold the FIFO packet count after this copy's pop, saturated at 255. Bits 19:0 hold the copied length. Bits 45:40 hold the head packet's flag input, with flag bit i at bit 40+i. All other bits are zero. Accepting a descriptor clears the done word to zero.
- R9: Each completed copy pulses `irq_rx_data` for one cycle. In that same cycle, `irq_rx_done` and `fifo_pop` pulse exactly when the packet has been fully delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rx_en | input | 1 | Receive enable |
| max_copy | input | LEN_W | Per-copy byte ceiling |
| desc_wr | input | 1 | Descriptor write strobe |
| desc_wdata | input | 64 | Descriptor value |
| done_word | output | 64 | Packed completion word |
| fifo_pkt_cnt | input | CNT_W | Packets held in the FIFO |
| fifo_head_len | input | LEN_W | Byte length of the head packet |
| fifo_head_flags | input | 6 | Protocol and checksum-error flags of the head packet |
| fifo_pop | output | 1 | Remove the head packet |
| mem_req | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Destination address |
| mem_len | output | LEN_W | Bytes to write |
| mem_off | output | LEN_W | Byte offset inside the packet |
| mem_ack | input | 1 | Memory write accepted |
| irq_rx_data | output | 1 | Copy-finished pulse |
| irq_rx_done | output | 1 | Packet-received pulse |

## Verification
Two events can land on the same clock edge: software posting a new descriptor, and the engine closing the current copy, which packs the done word and releases the pending slot. The bench provokes this collision by raising `desc_wr` in exactly the cycle where `irq_rx_data` is seen high. It then judges the outcome on three points: the done word must hold the finished copy's values, the new descriptor must be dropped, and no request may follow. A sweep over packet length, descriptor length and copy ceiling checks every split of a packet against arithmetic offsets, lengths and more-data flags.

// File: rtl/rxce_pkg.sv
package rxce_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FIFO_WAIT,
    ST_BEGIN,
    ST_COPY,
    ST_DONE
  } rxce_state_e;

  localparam int FLAG_W       = 6;
  localparam int DESC_LEN_LSB = 40;
  localparam int DW_COMPLETE  = 63;
  localparam int DW_MORE      = 32;
  localparam int DW_FLAG_LSB  = 40;
  localparam int DW_CNT_LSB   = 20;
  localparam int DW_CNT_W     = 8;
  localparam int DW_LEN_W     = 20;
endpackage

// File: rtl/rxce_len_sel.sv
module rxce_len_sel #(
  parameter int LEN_W = 20
) (
  input  logic [LEN_W-1:0] want_len,
  input  logic [LEN_W-1:0] cap_len,
  input  logic [LEN_W-1:0] left_len,
  output logic [LEN_W-1:0] sel_len
);
  logic [LEN_W-1:0] first_min;

  always_comb begin
    first_min = (want_len < cap_len) ? want_len : cap_len;
    sel_len   = (first_min < left_len) ? first_min : left_len;
  end
endmodule

// File: rtl/rxce_done_pack.sv
module rxce_done_pack
  import rxce_pkg::*;
#(
  parameter int LEN_W = 20,
  parameter int CNT_W = 10
) (
  input  logic              more,
  input  logic [CNT_W-1:0]  cnt,
  input  logic [LEN_W-1:0]  len,
  input  logic [FLAG_W-1:0] flags,
  output logic [63:0]       word
);
  localparam int CNT_SAT = (1 << DW_CNT_W) - 1;

  logic [DW_CNT_W-1:0] cnt_field;

  generate
    if (CNT_W > DW_CNT_W) begin : g_sat
      assign cnt_field = (cnt > CNT_W'(CNT_SAT)) ? DW_CNT_W'(CNT_SAT) : cnt[DW_CNT_W-1:0];
    end else begin : g_ext
      assign cnt_field = DW_CNT_W'(cnt);
    end
  endgenerate

  always_comb begin
    word                          = '0;
    word[DW_COMPLETE]             = 1'b1;
    word[DW_MORE]                 = more;
    word[DW_FLAG_LSB +: FLAG_W]   = flags;
    word[DW_CNT_LSB +: DW_CNT_W]  = cnt_field;
    word[0 +: LEN_W]              = len;
  end
endmodule

// File: rtl/rx_copy_engine.sv
module rx_copy_engine
  import rxce_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int LEN_W  = 20,
  parameter int CNT_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_rx_en,
  input  logic [LEN_W-1:0]  max_copy,
  input  logic              desc_wr,
  input  logic [63:0]       desc_wdata,
  output logic [63:0]       done_word,
  input  logic [CNT_W-1:0]  fifo_pkt_cnt,
  input  logic [LEN_W-1:0]  fifo_head_len,
  input  logic [FLAG_W-1:0] fifo_head_flags,
  output logic              fifo_pop,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LEN_W-1:0]  mem_len,
  output logic [LEN_W-1:0]  mem_off,
  input  logic              mem_ack,
  output logic              irq_rx_data,
  output logic              irq_rx_done
);
  rxce_state_e state_q, state_nxt;

  logic              pending_q;
  logic [ADDR_W-1:0] d_addr_q;
  logic [LEN_W-1:0]  d_len_q;
  logic              in_prog_q;
  logic [LEN_W-1:0]  remain_q;
  logic [LEN_W-1:0]  next_off_q;
  logic [LEN_W-1:0]  cp_off_q;
  logic [LEN_W-1:0]  cp_len_q;
  logic [FLAG_W-1:0] flags_q;

  logic [LEN_W-1:0]  rem_src, off_src, sel_len;
  logic [63:0]       packed_word;
  logic              desc_take, begin_en, done_en, pkt_finished;
  logic [CNT_W-1:0]  cnt_after;
  logic              unused_desc;

  assign unused_desc  = ^desc_wdata;
  assign desc_take    = desc_wr && !pending_q;
  assign begin_en     = (state_q == ST_BEGIN);
  assign done_en      = (state_q == ST_DONE);
  assign pkt_finished = (remain_q == '0);
  assign rem_src      = in_prog_q ? remain_q : fifo_head_len;
  assign off_src      = in_prog_q ? next_off_q : '0;
  assign cnt_after    = fifo_pkt_cnt - CNT_W'(fifo_pop);

  rxce_len_sel #(.LEN_W(LEN_W)) u_len_sel (
    .want_len (d_len_q),
    .cap_len  (max_copy),
    .left_len (rem_src),
    .sel_len  (sel_len)
  );

  rxce_done_pack #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_done_pack (
    .more  (!pkt_finished),
    .cnt   (cnt_after),
    .len   (cp_len_q),
    .flags (flags_q),
    .word  (packed_word)
  );

  // next-state logic
  always_comb begin
    state_nxt = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (pending_q && cfg_rx_en) begin
          if (!in_prog_q && (fifo_pkt_cnt == '0)) state_nxt = ST_FIFO_WAIT;
          else                                    state_nxt = ST_BEGIN;
        end
      end
      ST_FIFO_WAIT: begin
        if (!cfg_rx_en)                 state_nxt = ST_IDLE;
        else if (fifo_pkt_cnt != '0)    state_nxt = ST_BEGIN;
      end
      ST_BEGIN: state_nxt = (sel_len == '0) ? ST_DONE : ST_COPY;
      ST_COPY:  if (mem_ack) state_nxt = ST_DONE;
      ST_DONE:  state_nxt = ST_IDLE;
      default:  state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_nxt;
  end

  // descriptor slot and done word
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending_q <= 1'b0;
      d_addr_q  <= '0;
      d_len_q   <= '0;
      done_word <= '0;
    end else if (desc_take) begin
      pending_q <= 1'b1;
      d_addr_q  <= desc_wdata[ADDR_W-1:0];
      d_len_q   <= desc_wdata[DESC_LEN_LSB +: LEN_W];
      done_word <= '0;
    end else if (done_en) begin
      pending_q <= 1'b0;
      done_word <= packed_word;
    end
  end

  // per-copy bookkeeping of the head packet
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_prog_q  <= 1'b0;
      remain_q   <= '0;
      next_off_q <= '0;
      cp_off_q   <= '0;
      cp_len_q   <= '0;
      flags_q    <= '0;
    end else if (begin_en) begin
      cp_len_q   <= sel_len;
      cp_off_q   <= off_src;
      remain_q   <= rem_src - sel_len;
      next_off_q <= off_src + sel_len;
      if (!in_prog_q) flags_q <= fifo_head_flags;
    end else if (done_en) begin
      in_prog_q  <= !pkt_finished;
    end
  end

  assign mem_req     = (state_q == ST_COPY);
  assign mem_addr    = d_addr_q;
  assign mem_len     = cp_len_q;
  assign mem_off     = cp_off_q;
  assign irq_rx_data = done_en;
  assign irq_rx_done = done_en && pkt_finished;
  assign fifo_pop    = done_en && pkt_finished;

  p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_len) && $stable(mem_off)));

  p_req_nonzero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0));

  p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_pop |-> (fifo_pkt_cnt != '0));

  p_data_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_data |=> !irq_rx_data);

  p_done_complete_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rx_data |=> done_word[DW_COMPLETE]);

  p_no_start_disabled_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_IDLE) && !cfg_rx_en) |=> (state_q == ST_IDLE));

  p_take_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_wr && !pending_q) |=> (done_word == '0));
endmodule

// File: tb/rx_copy_engine_bench.sv
module rx_copy_engine_bench;
  localparam int ADDR_W = 40;
  localparam int LEN_W  = 20;
  localparam int CNT_W  = 10;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_rx_en;
  logic [LEN_W-1:0]  max_copy;
  logic              desc_wr;
  logic [63:0]       desc_wdata;
  logic [63:0]       done_word;
  logic [CNT_W-1:0]  fifo_pkt_cnt;
  logic [LEN_W-1:0]  fifo_head_len;
  logic [5:0]        fifo_head_flags;
  logic              fifo_pop;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic [LEN_W-1:0]  mem_len;
  logic [LEN_W-1:0]  mem_off;
  logic              mem_ack;
  logic              irq_rx_data;
  logic              irq_rx_done;

  int vectors = 0;
  int misses  = 0;

  always #5 clk = ~clk;

  rx_copy_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_rx_copy_engine (
    .clk, .rst_n, .cfg_rx_en, .max_copy, .desc_wr, .desc_wdata, .done_word,
    .fifo_pkt_cnt, .fifo_head_len, .fifo_head_flags, .fifo_pop,
    .mem_req, .mem_addr, .mem_len, .mem_off, .mem_ack, .irq_rx_data, .irq_rx_done
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] exp_word(input bit more, input int cnt, input int len, input logic [5:0] fl);
    logic [63:0] w;
    w         = '0;
    w[63]     = 1'b1;
    w[32]     = more;
    w[45:40]  = fl;
    w[27:20]  = (cnt > 255) ? 8'd255 : 8'(cnt);
    w[19:0]   = 20'(len);
    return w;
  endfunction

  task automatic write_desc(input logic [39:0] a, input int dlen);
    @(negedge clk);
    desc_wr    = 1'b1;
    desc_wdata = {4'h0, 20'(dlen), a};
    @(negedge clk);
    desc_wr    = 1'b0;
  endtask

  // completes one copy that has already been posted; collide posts another descriptor in the completion cycle
  task automatic finish_copy(input logic [39:0] a, input int len, input int off, input bit more,
                             input int cnt_before, input logic [5:0] fl, input bit collide);
    logic [63:0] w;
    for (int i = 0; i < 30; i++) begin
      if (mem_req || irq_rx_data) break;
      @(negedge clk);
    end
    if (len > 0) begin
      chk(mem_req, "R5 request", 64'(mem_req), 64'd1);
      chk(mem_addr == a, "R2 address", 64'(mem_addr), 64'(a));
      chk(mem_len == LEN_W'(len), "R5 length", 64'(mem_len), 64'(len));
      chk(mem_off == LEN_W'(off), "R6 offset", 64'(mem_off), 64'(off));
      mem_ack = 1'b1;
      @(negedge clk);
      mem_ack = 1'b0;
    end else begin
      chk(!mem_req, "R7 no request", 64'(mem_req), 64'd0);
    end
    chk(irq_rx_data, "R9 data pulse", 64'(irq_rx_data), 64'd1);
    chk(irq_rx_done == !more, "R9 done pulse", 64'(irq_rx_done), 64'(!more));
    chk(fifo_pop == !more, "R6 pop", 64'(fifo_pop), 64'(!more));
    if (collide) begin
      desc_wr    = 1'b1;
      desc_wdata = {4'h0, 20'd5, 40'h77_0000_0000};
    end
    @(negedge clk);
    desc_wr = 1'b0;
    if (!more) fifo_pkt_cnt = fifo_pkt_cnt - 1'b1;
    w = exp_word(more, more ? cnt_before : cnt_before - 1, len, fl);
    chk(done_word == w, "R8 done word", done_word, w);
    chk(!irq_rx_data, "R9 single pulse", 64'(irq_rx_data), 64'd0);
    if (collide) begin
      bit seen = 1'b0;
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (mem_req || irq_rx_data) seen = 1'b1;
      end
      chk(!seen, "R2 collision ignored", 64'(seen), 64'd0);
      chk(done_word == w, "R2 done word kept", done_word, w);
    end
  endtask

  task automatic run_copy(input logic [39:0] a, input int dlen, input int len, input int off,
                          input bit more, input logic [5:0] fl, input bit collide);
    int cb;
    cb = int'(fifo_pkt_cnt);
    write_desc(a, dlen);
    chk(done_word == 64'd0, "R8 cleared on descriptor", done_word, 64'd0);
    finish_copy(a, len, off, more, cb, fl, collide);
  endtask

  // whole packet of length plen delivered with descriptors of length dlen
  task automatic drain_packet(input int plen, input int dlen, input int mc, input int cnt,
                              input logic [5:0] fl, input logic [39:0] base);
    int rem, off, l;
    fifo_pkt_cnt    = CNT_W'(cnt);
    fifo_head_len   = LEN_W'(plen);
    fifo_head_flags = fl;
    max_copy        = LEN_W'(mc);
    rem = plen;
    off = 0;
    do begin
      l = dlen;
      if (mc < l)  l = mc;
      if (rem < l) l = rem;
      rem -= l;
      run_copy(base + 40'(off), dlen, l, off, rem != 0, fl, 1'b0);
      off += l;
    end while (rem != 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_rx_en = 1'b1; max_copy = '0; desc_wr = 1'b0; desc_wdata = '0;
    fifo_pkt_cnt = '0; fifo_head_len = '0; fifo_head_flags = '0; mem_ack = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(done_word == 64'd0, "R1 done word", done_word, 64'd0);
    chk(!mem_req && !fifo_pop, "R1 req/pop", {62'd0, mem_req, fifo_pop}, 64'd0);
    chk(!irq_rx_data && !irq_rx_done, "R1 pulses", {62'd0, irq_rx_data, irq_rx_done}, 64'd0);

    // R5 R6 R7 R8 R9 sweep over packet length, descriptor length and ceiling
    for (int mc = 1; mc <= 3; mc++)
      for (int pl = 0; pl <= 6; pl++)
        for (int dl = 1; dl <= 4; dl++)
          drain_packet(pl, dl, mc, 2, 6'((pl * 7 + dl) & 63), 40'h10_0000_0000 + 40'(pl << 8));

    // R3 disabled receive holds the descriptor
    begin
      bit seen = 1'b0;
      cfg_rx_en = 1'b0;
      fifo_pkt_cnt = 1; fifo_head_len = 3; fifo_head_flags = 6'h21; max_copy = 8;
      write_desc(40'h00_1234_5678, 8);
      for (int i = 0; i < 12; i++) begin
        @(negedge clk);
        if (mem_req || irq_rx_data) seen = 1'b1;
      end
      chk(!seen, "R3 held while disabled", 64'(seen), 64'd0);
      cfg_rx_en = 1'b1;
      finish_copy(40'h00_1234_5678, 3, 0, 1'b0, 1, 6'h21, 1'b0);
    end

    // R4 empty FIFO blocks; R2 second write while pending is ignored
    begin
      bit seen = 1'b0;
      fifo_pkt_cnt = 0; fifo_head_len = 4; fifo_head_flags = 6'h12; max_copy = 8;
      write_desc(40'h00_AAAA_0000, 6);
      for (int i = 0; i < 10; i++) begin
        @(negedge clk);
        if (mem_req || irq_rx_data) seen = 1'b1;
      end
      chk(!seen, "R4 blocked on empty FIFO", 64'(seen), 64'd0);
      write_desc(40'h00_BBBB_0000, 2);
      fifo_pkt_cnt = 1;
      finish_copy(40'h00_AAAA_0000, 4, 0, 1'b0, 1, 6'h12, 1'b0);
    end

    // R7 zero ceiling yields an empty copy, then the packet finishes
    fifo_pkt_cnt = 3; fifo_head_len = 5; fifo_head_flags = 6'h3F; max_copy = 0;
    run_copy(40'h00_0000_1000, 4, 0, 0, 1'b1, 6'h3F, 1'b0);
    max_copy = 8;
    run_copy(40'h00_0000_2000, 8, 5, 0, 1'b0, 6'h3F, 1'b0);

    // R8 saturation of the FIFO count field
    fifo_pkt_cnt = 300; fifo_head_len = 2; fifo_head_flags = 6'h01; max_copy = 4;
    run_copy(40'h00_0000_3000, 4, 2, 0, 1'b0, 6'h01, 1'b0);
    fifo_pkt_cnt = 256;
    run_copy(40'h00_0000_4000, 4, 2, 0, 1'b0, 6'h01, 1'b0);
    fifo_pkt_cnt = 255;
    run_copy(40'h00_0000_5000, 1, 1, 0, 1'b1, 6'h01, 1'b0);
    run_copy(40'h00_0000_5001, 1, 1, 1, 1'b0, 6'h01, 1'b0);

    // R2 descriptor posted in the completion cycle is dropped
    fifo_pkt_cnt = 2; fifo_head_len = 3; fifo_head_flags = 6'h08; max_copy = 8;
    run_copy(40'h00_0000_6000, 8, 3, 0, 1'b0, 6'h08, 1'b1);
    fifo_head_len = 2;
    run_copy(40'h00_0000_7000, 8, 2, 0, 1'b0, 6'h08, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule